// File: doc/BRIEF.md
# PHY Test-Port Configuration Slave

This block sits on the PHY side of a narrow configuration port. A master drives four slow pins: a clear, a strobe clock, an enable, and one 8-bit data bus. It uses them to pick a register and then write a byte into it. The address (called the test code) and the data travel on the same bus. The enable level at each strobe edge tells them apart: a falling strobe edge with enable high loads the code, and a rising strobe edge with enable low writes the data.

The small register file drives the rest of the PHY. It holds one control byte for the clock lane and one for each data lane. From each data-lane byte a range code is extracted. It also holds a settle-time threshold byte and a general mode byte. The port pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer before its edges are detected. The read-back bus continuously shows the register that the current code selects.

Top module: `tport_cfg_slave`

## Requirements
- R1: A falling edge of `tp_clk` while `tp_en` is high loads `tp_din` as the current code.
- R2: A rising edge of `tp_clk` while `tp_en` is low writes `tp_din` into the register selected by the current code. The implemented codes are: 0x00 mode (`mode_cfg`), 0x34 clock lane (`clk_lane_cfg`), 0x75 settle threshold (`settle_cfg`), and 0x44, 0x54, 0x84, 0x94 for data lanes 0 to 3. Lane k occupies bits [8k+7:8k] of `lane_cfg`.
- R3: A rising edge while `tp_en` is high writes nothing. A falling edge while `tp_en` is low leaves the current code unchanged.
- R4: A write under an unimplemented code changes no register.
- R5: While `tp_clr` is high, the current code returns to 0x00 and every register returns to zero.
- R6: `tp_dout` shows the register selected by the current code, and shows zero when the code is unimplemented.
- R7: `lane_range` bits [6k+5:6k] equal bits [6:1] of the lane-k control byte.
- R8: The pins pass through two synchronizer flops and one edge-detect stage. A pin change made between two system-clock edges therefore reaches `tp_dout` after the third rising edge, and not after the second.
- R9: While `rst_n` is low, the current code and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tp_clr | input | 1 | Port clear, asynchronous, active high |
| tp_clk | input | 1 | Port strobe clock, asynchronous |
| tp_en | input | 1 | Port enable: high selects code, low selects data |
| tp_din | input | 8 | Shared code/data bus |
| tp_dout | output | 8 | Contents of the selected register |
| mode_cfg | output | 8 | Mode register (code 0x00) |
| clk_lane_cfg | output | 8 | Clock-lane control (code 0x34) |
| settle_cfg | output | 8 | Settle threshold (code 0x75) |
| lane_cfg | output | 8*LANES | Data-lane control bytes, lane 0 in the LSBs |
| lane_range | output | 6*LANES | Range code per lane, lane 0 in the LSBs |

## Verification
The bench builds the block with its default of four lanes. With that setting every implemented code, including the highest lane code 0x94, has a register behind it, and the full lane-range vector can be compared against values computed from the written bytes. The vector walk writes each implemented code and two unimplemented ones, then reads the results back through `tp_dout`. The directed tests cover the two edges that must have no effect, the clear, the exact three-edge synchronizer latency, and the system reset.

// File: rtl/tport_pkg.sv
package tport_pkg;
    localparam int TP_W      = 8;
    localparam int RANGE_W   = 6;
    localparam int RANGE_LSB = 1;
    localparam int FIXED_REG = 3;    // mode, clock lane, settle

    // code of data lane k
    function automatic logic [TP_W-1:0] lane_code(input int k);
        case (k)
            0:       return 8'h44;
            1:       return 8'h54;
            2:       return 8'h84;
            default: return 8'h94;
        endcase
    endfunction

    // code of register slot i: 0 mode, 1 clock lane, 2 settle, 3+k lane k
    function automatic logic [TP_W-1:0] slot_code(input int i);
        case (i)
            0:       return 8'h00;
            1:       return 8'h34;
            2:       return 8'h75;
            default: return lane_code(i - FIXED_REG);
        endcase
    endfunction
endpackage

// File: rtl/tport_sync.sv
module tport_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/tport_front.sv
module tport_front
    import tport_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_a,
    input  logic            tclk_a,
    input  logic            en_a,
    input  logic [TP_W-1:0] din_a,
    output logic            clr_s,
    output logic [TP_W-1:0] din_s,
    output logic            wr_stb,
    output logic [TP_W-1:0] code_q
);
    localparam int SW = TP_W + 3;

    logic [SW-1:0] raw, synced;
    logic          tclk_s, en_s, rise, fall;

    assign raw = {clr_a, tclk_a, en_a, din_a};

    tport_sync #(.W(SW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    assign {clr_s, tclk_s, en_s, din_s} = synced;

    typedef struct packed {
        logic            prev;
        logic [TP_W-1:0] code;
    } front_t;

    front_t fr_d, fr_q;

    always_comb begin
        rise      = tclk_s & ~fr_q.prev;
        fall      = ~tclk_s & fr_q.prev;
        fr_d      = fr_q;
        fr_d.prev = tclk_s;
        if (clr_s)             fr_d.code = '0;
        else if (fall && en_s) fr_d.code = din_s;
        wr_stb    = rise & ~en_s & ~clr_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign code_q = fr_q.code;

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && en_s && !clr_s) |=> (code_q == $past(din_s)));
    p_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fall && en_s) && !clr_s) |=> $stable(code_q));
    p_clr_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> (code_q == '0));
    p_no_wr_en_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s || clr_s) |-> !wr_stb);
endmodule

// File: rtl/tport_regfile.sv
module tport_regfile
    import tport_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_s,
    input  logic                     wr_stb,
    input  logic [TP_W-1:0]          code,
    input  logic [TP_W-1:0]          wdata,
    output logic [TP_W-1:0]          rdata,
    output logic [TP_W-1:0]          mode_cfg,
    output logic [TP_W-1:0]          clk_lane_cfg,
    output logic [TP_W-1:0]          settle_cfg,
    output logic [LANES*TP_W-1:0]    lane_cfg,
    output logic [LANES*RANGE_W-1:0] lane_range
);
    localparam int NREG = FIXED_REG + LANES;

    typedef struct packed {
        logic [NREG-1:0][TP_W-1:0] regs;
    } rf_t;

    rf_t              rf_d, rf_q;
    logic [NREG-1:0]  hit;

    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign hit[i] = (code == slot_code(i));
    end

    always_comb begin
        rf_d = rf_q;
        if (clr_s) begin
            rf_d.regs = '0;
        end else if (wr_stb) begin
            for (int i = 0; i < NREG; i++)
                if (hit[i]) rf_d.regs[i] = wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) rdata = rdata | rf_q.regs[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign mode_cfg     = rf_q.regs[0];
    assign clk_lane_cfg = rf_q.regs[1];
    assign settle_cfg   = rf_q.regs[2];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_cfg[k*TP_W +: TP_W]         = rf_q.regs[FIXED_REG+k];
        assign lane_range[k*RANGE_W +: RANGE_W] =
            rf_q.regs[FIXED_REG+k][RANGE_LSB +: RANGE_W];
    end

    p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (rdata == '0));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!wr_stb || hit == '0) && !clr_s) |=> $stable(rf_q));
    p_clr_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> (rf_q == '0));
endmodule

// File: rtl/tport_cfg_slave.sv
module tport_cfg_slave
    import tport_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tp_clr,
    input  logic                     tp_clk,
    input  logic                     tp_en,
    input  logic [7:0]               tp_din,
    output logic [7:0]               tp_dout,
    output logic [7:0]               mode_cfg,
    output logic [7:0]               clk_lane_cfg,
    output logic [7:0]               settle_cfg,
    output logic [LANES*8-1:0]       lane_cfg,
    output logic [LANES*RANGE_W-1:0] lane_range
);
    logic            clr_s, wr_stb;
    logic [TP_W-1:0] din_s, code_q;

    tport_front u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_a  (tp_clr),
        .tclk_a (tp_clk),
        .en_a   (tp_en),
        .din_a  (tp_din),
        .clr_s  (clr_s),
        .din_s  (din_s),
        .wr_stb (wr_stb),
        .code_q (code_q)
    );

    tport_regfile #(.LANES(LANES)) u_rf (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_s        (clr_s),
        .wr_stb       (wr_stb),
        .code         (code_q),
        .wdata        (din_s),
        .rdata        (tp_dout),
        .mode_cfg     (mode_cfg),
        .clk_lane_cfg (clk_lane_cfg),
        .settle_cfg   (settle_cfg),
        .lane_cfg     (lane_cfg),
        .lane_range   (lane_range)
    );

    initial begin
        assert (LANES >= 1 && LANES <= 4) else $error("LANES out of range");
    end

    p_rst_zero_r9: assert property (@(posedge clk)
        !rst_n |-> (tp_dout == '0 && mode_cfg == '0));
endmodule

// File: tb/tb_tport_cfg_slave.sv
module tb_tport_cfg_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tp_clr = 1'b0, tp_clk = 1'b0, tp_en = 1'b0;
    logic [7:0]  tp_din = 8'h00;
    logic [7:0]  tp_dout, mode_cfg, clk_lane_cfg, settle_cfg;
    logic [31:0] lane_cfg;
    logic [23:0] lane_range;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    tport_cfg_slave #(.LANES(4)) dut (
        .clk(clk), .rst_n(rst_n), .tp_clr(tp_clr), .tp_clk(tp_clk),
        .tp_en(tp_en), .tp_din(tp_din), .tp_dout(tp_dout),
        .mode_cfg(mode_cfg), .clk_lane_cfg(clk_lane_cfg),
        .settle_cfg(settle_cfg), .lane_cfg(lane_cfg), .lane_range(lane_range)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // pins change just after a falling clock edge, then settle
    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] code, input logic [7:0] data);
        tp_clk = 1'b1; settle();
        tp_din = code; settle();
        tp_en  = 1'b1; settle();
        tp_clk = 1'b0; settle();
        tp_en  = 1'b0; settle();
        tp_din = data; settle();
        tp_clk = 1'b1; settle();
    endtask

    // code, data, expected read-back
    localparam logic [23:0] VEC [9] = '{
        {8'h34, 8'hA5, 8'hA5},
        {8'h44, 8'h3C, 8'h3C},
        {8'h54, 8'h81, 8'h81},
        {8'h84, 8'h7E, 8'h7E},
        {8'h94, 8'h0F, 8'h0F},
        {8'h75, 8'h04, 8'h04},
        {8'h00, 8'h5A, 8'h5A},
        {8'h55, 8'hFF, 8'h00},
        {8'h35, 8'h11, 8'h00}
    };

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset dout", tp_dout, 0);
        chk("R9 reset lanes", lane_cfg, 0);
        rst_n = 1'b1;
        settle();

        // R1 R2 R6 R4: vector walk
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            chk("R2 R6 R4 read-back", tp_dout, VEC[i][7:0]);
        end
        chk("R2 mode", mode_cfg, 8'h5A);
        chk("R2 clock lane", clk_lane_cfg, 8'hA5);
        chk("R2 settle", settle_cfg, 8'h04);
        chk("R2 R4 lanes", lane_cfg, 32'h0F7E813C);
        chk("R7 lane range", lane_range, {6'h07, 6'h3F, 6'h00, 6'h1E});

        // R1: select 0x34 without writing
        tp_din = 8'h34; settle();
        tp_en  = 1'b1;  settle();
        tp_clk = 1'b0;  settle();
        tp_en  = 1'b0;  settle();
        chk("R1 code select", tp_dout, 8'hA5);

        // R3: rising edge with enable high
        tp_en  = 1'b1;  settle();
        tp_din = 8'h99; settle();
        tp_clk = 1'b1;  settle();
        chk("R3 no write en high", clk_lane_cfg, 8'hA5);
        chk("R3 dout after en-high rise", tp_dout, 8'hA5);
        tp_en  = 1'b0;  settle();
        tp_clk = 1'b0;  settle();
        chk("R3 code kept on en-low fall", tp_dout, 8'hA5);

        // R5: clear
        tp_clr = 1'b1; settle();
        chk("R5 clear lanes", lane_cfg, 0);
        chk("R5 clear clock lane", clk_lane_cfg, 0);
        tp_clr = 1'b0; settle();
        tp_din = 8'h77; settle();
        tp_clk = 1'b1;  settle();
        chk("R5 code reset to 0x00", mode_cfg, 8'h77);
        chk("R5 R6 dout", tp_dout, 8'h77);

        // R8: latency of a code capture
        tp_din = 8'h34; settle();
        tp_en  = 1'b1;  settle();
        tp_clk = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 not yet after two edges", tp_dout, 8'h77);
        @(posedge clk);
        @(negedge clk);
        chk("R8 visible after third edge", tp_dout, 8'h00);
        tp_en = 1'b0; settle();

        // R9: system reset clears registers
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset mode", mode_cfg, 0);
        rst_n = 1'b1;
        settle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule